// File: doc/BRIEF.md
# PHY Management Interrupt Controller

This block gathers completion and status events from a PHY management engine and turns them into one active-high interrupt request. Four event sources are tracked separately. The first is a host-issued read or write through the PHY data port finishing. The second is an internally issued management operation finishing, for example a frame generated by the auto-poll machine. The third is an auto-poll read whose status word differs from the last one seen. The fourth is a management read that reports an error. Each source has a sticky status flag and an enable bit. The interrupt output is raised while any flag and its enable are both set.

Host software reads the flag and enable vectors directly from the block's outputs. It writes them through a one-bit register select. Flags are cleared by writing ones to them. Enables are written as plain data. The block keeps a shadow of the last auto-polled status word. Any change of the auto-poll access-method select invalidates that shadow. A hard reset clears all state. The soft reset and stop inputs leave the flags and enables untouched.

Top module: `mgmt_irq_ctrl`

## Requirements
- R1: Flag bit 0 (host command done) sets on the clock edge that samples `host_op_done` high. Internal operations and auto-poll activity never set bit 0.
- R2: Flag bit 1 (internal command done) sets on the clock edge that samples `int_op_done` high.
- R3: Flag bit 2 (auto-poll change) sets when `poll_done` is sampled with a `poll_status` different from the shadow. Every sampled `poll_done` loads `poll_status` into the shadow, so a repeated identical status does not set bit 2 again.
- R4: Several `poll_done` samples only load the shadow and cannot set bit 2: the first one after a hard reset, the first one after any change of `poll_mode`, and one that arrives in the same cycle as a `poll_mode` change.
- R5: Flag bit 3 (read error) sets on the clock edge that samples `rd_err` high.
- R6: A register write with `csr_sel`=0 clears every flag whose `csr_wdata` bit is 1. Flags whose `csr_wdata` bit is 0 keep their value.
- R7: A register write with `csr_sel`=1 loads `csr_wdata` into the enable vector. `irq` is high exactly when some bit is set in both `flags` and `enables`.
- R8: While `hrst_n` is low, all flags and enables are 0. `soft_rst` and `stop` have no effect on flags, enables or `irq`.
- R9: If a set event and a write-1-to-clear reach the same flag in the same cycle, the flag ends up set.
- R10: With the default `REG_IRQ`=0, `flags`, `enables` and `irq` show the result of an event or write directly after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset; no effect on this block's state |
| stop | input | 1 | Stop control; no effect on this block's state |
| host_op_done | input | 1 | One-cycle pulse: host data-port operation finished |
| int_op_done | input | 1 | One-cycle pulse: internal management operation finished |
| rd_err | input | 1 | One-cycle pulse: management read reported an error |
| poll_done | input | 1 | One-cycle pulse: auto-poll read finished, `poll_status` valid |
| poll_status | input | STATUS_W | Status word from the auto-poll read |
| poll_mode | input | 1 | Auto-poll access-method select |
| csr_wr | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 = flag register (write 1 to clear), 1 = enable register |
| csr_wdata | input | 4 | Write data, bit i maps to source i |
| flags | output | 4 | Status flags: bit0 host, bit1 internal, bit2 auto-poll, bit3 read error |
| enables | output | 4 | Enable bits, same mapping as `flags` |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest situations to reach from the ports involve the shadow register. One is an auto-poll read that lands in the very cycle `poll_mode` toggles. Another is the pair of reads that follows: a mismatching read right after the change must stay silent, and the next mismatching read must raise the flag. The directed stimulus toggles `poll_mode` with and without a simultaneous `poll_done`. It then issues differing status words back to back. A long random phase follows, with frequent mode toggles and sparse hard resets. Every clock is compared against a behavioural model of the flags, enables and interrupt.

// File: rtl/mgmt_irq_pkg.sv
package mgmt_irq_pkg;

   // number of interrupt sources tracked by the controller
   localparam int unsigned NSRC = 4;

   // bit position of each source in the flag and enable vectors
   typedef enum int unsigned {
      SRC_HOST  = 0,
      SRC_INT   = 1,
      SRC_POLL  = 2,
      SRC_RDERR = 3
   } src_e;

   typedef logic [NSRC-1:0] src_vec_t;

   // register select encoding
   localparam logic SEL_FLAGS   = 1'b0;
   localparam logic SEL_ENABLES = 1'b1;

endpackage

// File: rtl/mgmt_irq_flag.sv
module mgmt_irq_flag (
   input  logic clk,
   input  logic hrst_n,
   input  logic set_i,
   input  logic clr_wr_i,
   input  logic clr_bit_i,
   input  logic en_wr_i,
   input  logic en_bit_i,
   output logic flag_o,
   output logic en_o
);

   always_ff @(posedge clk or negedge hrst_n) begin
      if (!hrst_n) begin
         flag_o <= 1'b0;
         en_o   <= 1'b0;
      end else begin
         if (set_i)
            flag_o <= 1'b1;
         else if (clr_wr_i && clr_bit_i)
            flag_o <= 1'b0;
         if (en_wr_i)
            en_o <= en_bit_i;
      end
   end

   // a hardware event always survives a simultaneous clear
   assert_set_wins_R9 : assert property (@(posedge clk) disable iff (!hrst_n)
      set_i |=> flag_o);

   // writing one with no event clears the flag
   assert_w1c_clears_R6 : assert property (@(posedge clk) disable iff (!hrst_n)
      (clr_wr_i && clr_bit_i && !set_i) |=> !flag_o);

   // writing zero with no event keeps the flag
   assert_zero_keeps_R6 : assert property (@(posedge clk) disable iff (!hrst_n)
      (!set_i && !(clr_wr_i && clr_bit_i)) |=> $stable(flag_o));

endmodule

// File: rtl/mgmt_irq_poll_cmp.sv
module mgmt_irq_poll_cmp #(
   parameter int unsigned STATUS_W = 16
) (
   input  logic                clk,
   input  logic                hrst_n,
   input  logic                poll_done_i,
   input  logic [STATUS_W-1:0] status_i,
   input  logic                mode_i,
   output logic                change_o
);

   logic [STATUS_W-1:0] shadow_q;
   logic                primed_q;
   logic                mode_q;
   logic                mode_chg;

   assign mode_chg = (mode_i != mode_q);

   // the compare is valid only when the shadow is primed under the current mode
   assign change_o = poll_done_i && primed_q && !mode_chg && (status_i != shadow_q);

   always_ff @(posedge clk or negedge hrst_n) begin
      if (!hrst_n) begin
         shadow_q <= '0;
         primed_q <= 1'b0;
         mode_q   <= 1'b0;
      end else begin
         mode_q <= mode_i;
         if (poll_done_i) begin
            shadow_q <= status_i;
            primed_q <= 1'b1;
         end else if (mode_chg) begin
            shadow_q <= '0;
            primed_q <= 1'b0;
         end
      end
   end

   // the poll that follows a mode change or reset only primes the shadow
   assert_first_poll_quiet_R4 : assert property (@(posedge clk) disable iff (!hrst_n)
      (poll_done_i && (!primed_q || mode_chg)) |-> !change_o);

   // every poll reloads the shadow with the sampled status
   assert_shadow_load_R3 : assert property (@(posedge clk) disable iff (!hrst_n)
      poll_done_i |=> (shadow_q == $past(status_i)) && primed_q);

endmodule

// File: rtl/mgmt_irq_ctrl.sv
module mgmt_irq_ctrl
   import mgmt_irq_pkg::*;
#(
   parameter int unsigned STATUS_W = 16,
   parameter int unsigned REG_IRQ  = 0
) (
   input  logic                clk,
   input  logic                hrst_n,
   input  logic                soft_rst,
   input  logic                stop,
   input  logic                host_op_done,
   input  logic                int_op_done,
   input  logic                rd_err,
   input  logic                poll_done,
   input  logic [STATUS_W-1:0] poll_status,
   input  logic                poll_mode,
   input  logic                csr_wr,
   input  logic                csr_sel,
   input  logic [NSRC-1:0]     csr_wdata,
   output logic [NSRC-1:0]     flags,
   output logic [NSRC-1:0]     enables,
   output logic                irq
);

   if (STATUS_W < 1) begin : g_bad_width
      $error("mgmt_irq_ctrl: STATUS_W must be at least 1");
   end
   if (REG_IRQ > 1) begin : g_bad_regirq
      $error("mgmt_irq_ctrl: REG_IRQ must be 0 or 1");
   end

   src_vec_t set_vec;
   logic     poll_change;
   logic     flag_wr;
   logic     en_wr;
   logic     irq_any;

   mgmt_irq_poll_cmp #(
      .STATUS_W (STATUS_W)
   ) u_poll (
      .clk         (clk),
      .hrst_n      (hrst_n),
      .poll_done_i (poll_done),
      .status_i    (poll_status),
      .mode_i      (poll_mode),
      .change_o    (poll_change)
   );

   always_comb begin
      set_vec            = '0;
      set_vec[SRC_HOST]  = host_op_done;
      set_vec[SRC_INT]   = int_op_done;
      set_vec[SRC_POLL]  = poll_change;
      set_vec[SRC_RDERR] = rd_err;
   end

   assign flag_wr = csr_wr && (csr_sel == SEL_FLAGS);
   assign en_wr   = csr_wr && (csr_sel == SEL_ENABLES);

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      mgmt_irq_flag u_flag (
         .clk       (clk),
         .hrst_n    (hrst_n),
         .set_i     (set_vec[i]),
         .clr_wr_i  (flag_wr),
         .clr_bit_i (csr_wdata[i]),
         .en_wr_i   (en_wr),
         .en_bit_i  (csr_wdata[i]),
         .flag_o    (flags[i]),
         .en_o      (enables[i])
      );
   end

   assign irq_any = |(flags & enables);

   if (REG_IRQ == 1) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge hrst_n) begin
         if (!hrst_n) irq_q <= 1'b0;
         else         irq_q <= irq_any;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_any;
   end

   // only a host data-port completion may raise the host flag
   assert_host_flag_source_R1 : assert property (@(posedge clk) disable iff (!hrst_n)
      $rose(flags[SRC_HOST]) |-> $past(host_op_done));

   // the internal flag rises only after an internal completion
   assert_int_flag_source_R2 : assert property (@(posedge clk) disable iff (!hrst_n)
      $rose(flags[SRC_INT]) |-> $past(int_op_done));

   // the read-error flag rises only after a read-error pulse
   assert_rderr_flag_source_R5 : assert property (@(posedge clk) disable iff (!hrst_n)
      $rose(flags[SRC_RDERR]) |-> $past(rd_err));

   // soft reset and stop leave the state alone
   assert_soft_stop_inert_R8 : assert property (@(posedge clk) disable iff (!hrst_n)
      ((soft_rst || stop) && !csr_wr && !host_op_done && !int_op_done && !rd_err && !poll_done)
      |=> ($stable(flags) && $stable(enables)));

   // the enable register takes the written data
   assert_enable_load_R7 : assert property (@(posedge clk) disable iff (!hrst_n)
      en_wr |=> (enables == $past(csr_wdata)));

endmodule

// File: tb/mgmt_irq_ctrl_test.sv
`timescale 1ns/1ps
module mgmt_irq_ctrl_test;
   localparam int SW = 16;

   logic          clk = 1'b0;
   logic          hrst_n, soft_rst, stop;
   logic          host_op_done, int_op_done, rd_err, poll_done;
   logic [SW-1:0] poll_status;
   logic          poll_mode, csr_wr, csr_sel;
   logic [3:0]    csr_wdata;
   logic [3:0]    flags, enables;
   logic          irq;

   int errors = 0;
   int checks = 0;
   string cur_req = "R8";

   // behavioural reference state
   logic [3:0]    m_flag, m_en;
   logic [SW-1:0] m_shadow;
   logic          m_primed, m_mode;

   always #5 clk = ~clk;

   mgmt_irq_ctrl #(.STATUS_W(SW), .REG_IRQ(0)) uut (
      .clk(clk), .hrst_n(hrst_n), .soft_rst(soft_rst), .stop(stop),
      .host_op_done(host_op_done), .int_op_done(int_op_done), .rd_err(rd_err),
      .poll_done(poll_done), .poll_status(poll_status), .poll_mode(poll_mode),
      .csr_wr(csr_wr), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
      .flags(flags), .enables(enables), .irq(irq)
   );

   task automatic chk(input string what, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", cur_req, what, act, exp);
      end
   endtask

   task automatic quiet();
      host_op_done = 0; int_op_done = 0; rd_err = 0; poll_done = 0;
      csr_wr = 0; csr_sel = 0; csr_wdata = 0; soft_rst = 0; stop = 0;
   endtask

   // one clock: compute the model's next state from the driven inputs,
   // pass one rising edge, compare at the following falling edge (R10)
   task automatic tick();
      logic [3:0] ev, clr, nf, ne;
      logic [SW-1:0] nsh;
      logic np, chg;
      if (!hrst_n) begin
         nf = 0; ne = 0; nsh = 0; np = 0;
      end else begin
         chg = (poll_mode != m_mode);
         ev = {rd_err,
               poll_done && m_primed && !chg && (poll_status != m_shadow),
               int_op_done, host_op_done};
         clr = (csr_wr && !csr_sel) ? csr_wdata : 4'b0;
         nf = (m_flag & ~clr) | ev;
         ne = (csr_wr && csr_sel) ? csr_wdata : m_en;
         nsh = m_shadow; np = m_primed;
         if (poll_done) begin nsh = poll_status; np = 1; end
         else if (chg) begin nsh = 0; np = 0; end
      end
      @(negedge clk);
      m_flag = nf; m_en = ne; m_shadow = nsh; m_primed = np;
      m_mode = hrst_n ? poll_mode : 1'b0;
      chk("flags", flags, m_flag);
      chk("enables", enables, m_en);
      chk("irq", {3'b0, irq}, {3'b0, |(m_flag & m_en)});
      quiet();
   endtask

   task automatic poll(input logic [SW-1:0] s);
      poll_done = 1; poll_status = s; tick();
   endtask

   task automatic wr(input logic sel, input logic [3:0] d);
      csr_wr = 1; csr_sel = sel; csr_wdata = d; tick();
   endtask

   initial begin
      #1_000_000;
      errors++; checks++;
      $display("FAIL R10 watchdog actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      quiet();
      poll_status = 0; poll_mode = 0; hrst_n = 0;
      m_flag = 0; m_en = 0; m_shadow = 0; m_primed = 0; m_mode = 0;
      @(negedge clk);
      cur_req = "R8"; tick(); tick();           // R8 reset state
      hrst_n = 1; tick();

      cur_req = "R7"; wr(1, 4'b1111);            // R7 enable all
      cur_req = "R1"; host_op_done = 1; tick();  // R1 host completion
      cur_req = "R6"; wr(0, 4'b1110); wr(0, 4'b0001);  // R6 zero keeps, one clears
      cur_req = "R2"; int_op_done = 1; tick();   // R2 internal completion
      cur_req = "R5"; rd_err = 1; tick();        // R5 read error
      cur_req = "R6"; wr(0, 4'b1010);
      cur_req = "R4"; poll(16'hA5A5);            // R4 first poll after reset is quiet
      cur_req = "R3"; poll(16'hA5A5); poll(16'h0001);  // R3 same then different
      cur_req = "R6"; wr(0, 4'b0100);
      cur_req = "R3"; poll(16'h0001);            // R3 unchanged status: no retrigger
      cur_req = "R4"; poll_mode = 1; tick();     // R4 mode change
      poll(16'h7777); poll(16'h8888);            // R4 quiet, then flagged
      wr(0, 4'b1111);
      poll_mode = 0; poll(16'h1234);             // R4 poll with simultaneous change
      poll(16'h4321);
      cur_req = "R9"; host_op_done = 1; csr_wr = 1; csr_sel = 0; csr_wdata = 4'b1111; tick(); // R9
      cur_req = "R8"; soft_rst = 1; stop = 1; tick(); soft_rst = 1; tick(); // R8 inert controls
      cur_req = "R7"; wr(1, 4'b0000); wr(1, 4'b0001);   // R7 irq masking
      cur_req = "R8"; hrst_n = 0; tick(); hrst_n = 1; tick(); // R8 hard reset
      cur_req = "R4"; poll(16'hFFFF);            // R4 first poll after hard reset

      cur_req = "R10";
      for (int n = 0; n < 4000; n++) begin
         host_op_done = ($urandom_range(0, 9) == 0);
         int_op_done  = ($urandom_range(0, 9) == 0);
         rd_err       = ($urandom_range(0, 14) == 0);
         poll_done    = ($urandom_range(0, 3) == 0);
         poll_status  = SW'($urandom_range(0, 3));
         if ($urandom_range(0, 11) == 0) poll_mode = ~poll_mode;
         csr_wr    = ($urandom_range(0, 4) == 0);
         csr_sel   = 1'($urandom_range(0, 1));
         csr_wdata = 4'($urandom_range(0, 15));
         soft_rst  = ($urandom_range(0, 7) == 0);
         stop      = ($urandom_range(0, 7) == 0);
         hrst_n    = ($urandom_range(0, 299) != 0);
         tick();
         hrst_n = 1;
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule